// File: doc/BRIEF.md
# Folded Symmetric FIR Engine

This block is a time-multiplexed FIR filter built around one multiply-accumulate unit. Every accepted input sample goes into a circular history memory. The engine then walks the taps one per clock and produces one rounded, saturated result for that sample. A writable coefficient store holds 256 entries.

In asymmetric mode each entry weights one tap, so the filter can have up to 256 taps. In symmetric mode entry k weights both tap k and tap N-1-k. The two history samples for that pair are added before the multiply. The same store then covers up to 512 taps, and each output takes half as many cycles as taps.

The tap count and the mode are sampled together with each accepted sample. The coefficient store is loaded through a plain write port.

Top module: `fir_fold_core`

## Requirements
- R1: After synchronous reset, out_valid, busy and overrun are low and out_data is zero.
- R2: In asymmetric mode (sym_mode=0), y(n) = sum over k<N of c[k]*x(n-k). Here c[k] is coefficient entry k and x(n) is the sample just accepted. A tap_count of 0 counts as 1, and a tap_count above 256 is limited to 256.
- R3: In symmetric mode (sym_mode=1), y(n) = sum over k<ceil(N/2) of c[k]*(x(n-k)+x(n-N+1+k)). When N is odd, the centre term is used once and not doubled. A tap_count above 512 is limited to 512.
- R4: out_valid rises on the (M+2)-th rising edge after the edge that accepts a sample. M is N in asymmetric mode and ceil(N/2) in symmetric mode.
- R5: The output is floor((acc + 2^(F-1)) / 2^F) with F = CW-1, saturated to the signed OW-bit range.
- R6: busy is high from the edge after acceptance. out_valid is high for exactly one cycle, and busy falls on the edge after that pulse.
- R7: An in_valid seen while busy is high raises overrun for one cycle. That sample is discarded: it never enters the history, and the running result is unchanged.
- R8: Changes to tap_count or sym_mode after acceptance do not affect the running result.
- R9: A coef_we pulse stores coef_wdata at entry coef_addr, and later outputs use the new value.
- R10: Sample history persists across outputs and across changes of tap count. Never-written history reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| tap_count | input | log2(TAPS)+1 | Requested tap count N |
| sym_mode | input | 1 | 1 = symmetric folding, 0 = asymmetric |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(CDEPTH) | Coefficient entry index |
| coef_wdata | input | CW | Signed coefficient, CW-1 fraction bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OW | Signed rounded and saturated result |
| busy | output | 1 | A computation is in flight |
| overrun | output | 1 | One-cycle flag for a dropped sample |

## Verification
Some properties are checked on every cycle:
- the result strobe lasts one cycle,
- a result appears only while busy, and busy drops right after it,
- the tap counter stays below the iteration count,
- the pipeline's last-term marker always travels with a valid term,
- the write pointer does not move when a sample is dropped.

The arithmetic can only be shown by the bench's scenarios, which compare against an independent model of the history and the coefficients. These scenarios cover pair folding and the centre tap, tap-count clamping, rounding at exact halves, saturation at both rails, exact latency, the latching of settings and the exclusion of dropped samples.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} fir_state_e;
endpackage

// File: rtl/fir_sdp_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module fir_sdp_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_fold_ctrl.sv
// Sequencer: accepts samples, walks taps, issues history/coef addresses.
module fir_fold_ctrl
  import fir_fold_pkg::*;
#(
  parameter int TAPS   = 512,
  parameter int CDEPTH = 256,
  localparam int PTRW  = $clog2(TAPS),
  localparam int CAW   = $clog2(CDEPTH),
  localparam int NW    = $clog2(TAPS) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [NW-1:0]   tap_count,
  input  logic            sym_mode,
  input  logic            done,
  output logic            wr_en,
  output logic [PTRW-1:0] wr_addr,
  output logic [PTRW-1:0] rd_a,
  output logic [PTRW-1:0] rd_b,
  output logic [CAW-1:0]  c_addr,
  output logic            iss_valid,
  output logic            iss_last,
  output logic            iss_center,
  output logic            iss_sym,
  output logic            busy,
  output logic            overrun
);
  fir_state_e     state;
  logic [NW-1:0]   k, iters_r, nm1_r, n_req, n_eff, iters_nx;
  logic [PTRW-1:0] head, newest;
  logic            sym_r, accept, last_k;

  always_comb begin
    n_req = (tap_count == '0) ? NW'(1) : tap_count;
    if (!sym_mode && n_req > NW'(CDEPTH)) n_eff = NW'(CDEPTH);
    else if (n_req > NW'(TAPS))           n_eff = NW'(TAPS);
    else                                  n_eff = n_req;
    iters_nx = sym_mode ? ((n_eff + NW'(1)) >> 1) : n_eff;
  end

  assign accept  = in_valid && !busy;
  assign last_k  = (k == iters_r - NW'(1));
  assign wr_en   = accept;
  assign wr_addr = head;
  assign rd_a    = newest - PTRW'(k);
  assign rd_b    = newest - PTRW'(nm1_r - k);
  assign c_addr  = CAW'(k);
  assign iss_sym = sym_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      k          <= '0;
      iters_r    <= NW'(1);
      nm1_r      <= '0;
      sym_r      <= 1'b0;
      head       <= '0;
      newest     <= '0;
      busy       <= 1'b0;
      overrun    <= 1'b0;
      iss_valid  <= 1'b0;
      iss_last   <= 1'b0;
      iss_center <= 1'b0;
    end else begin
      overrun    <= in_valid && busy;
      iss_valid  <= 1'b0;
      iss_last   <= 1'b0;
      iss_center <= 1'b0;
      if (accept) begin
        head    <= head + PTRW'(1);
        newest  <= head;
        state   <= ST_RUN;
        k       <= '0;
        iters_r <= iters_nx;
        nm1_r   <= n_eff - NW'(1);
        sym_r   <= sym_mode;
        busy    <= 1'b1;
      end else if (state == ST_RUN) begin
        iss_valid  <= 1'b1;
        iss_last   <= last_k;
        iss_center <= sym_r && ({k, 1'b0} == {1'b0, nm1_r});
        k          <= k + NW'(1);
        if (last_k) state <= ST_IDLE;
      end
      if (done) busy <= 1'b0;
    end
  end

  // R4: the tap walk never runs past its iteration count
  a_r4_k_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (k < iters_r));
  // R7: a dropped sample leaves the write pointer alone
  a_r7_head_hold: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $stable(head));
endmodule

// File: rtl/fir_fold_mac.sv
// Pre-add, multiply, accumulate, round and saturate.
module fir_fold_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int ACCW = 41,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic                 in_center,
  input  logic                 in_sym,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [CW-1:0] coef,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);
  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW:0] MAXV = (ACCW+1)'((longint'(1) <<< (OW - 1)) - 1);
  localparam logic signed [ACCW:0] MINV = -MAXV - (ACCW+1)'(1);

  logic signed [DW:0]    pre;
  logic signed [DW+CW:0] prod_r;
  logic signed [ACCW-1:0] acc, tot;
  logic signed [ACCW:0]   rnd, shv;
  logic v2, l2;

  always_comb begin
    pre = $signed({a[DW-1], a});
    if (in_sym && !in_center) pre = pre + $signed({b[DW-1], b});
    tot = acc + ACCW'(prod_r);
    rnd = $signed({tot[ACCW-1], tot}) + HALF;
    shv = rnd >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_r    <= '0;
      v2        <= 1'b0;
      l2        <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v2        <= in_valid;
      l2        <= in_valid && in_last;
      if (in_valid) prod_r <= pre * coef;
      out_valid <= 1'b0;
      if (v2) begin
        if (l2) begin
          acc       <= '0;
          out_valid <= 1'b1;
          if (shv > MAXV)      out_data <= {1'b0, {(OW-1){1'b1}}};
          else if (shv < MINV) out_data <= {1'b1, {(OW-1){1'b0}}};
          else                 out_data <= shv[OW-1:0];
        end else begin
          acc <= tot;
        end
      end
    end
  end

  // R6: result strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R4: the closing term of a sum always arrives with a valid product
  a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
    l2 |-> v2);
endmodule

// File: rtl/fir_fold_core.sv
// Top: folded single-MAC FIR with symmetric / asymmetric modes.
module fir_fold_core #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 16,
  parameter int TAPS   = 512,
  parameter int CDEPTH = 256,
  localparam int PTRW  = $clog2(TAPS),
  localparam int CAW   = $clog2(CDEPTH),
  localparam int NW    = $clog2(TAPS) + 1,
  localparam int ACCW  = DW + 1 + CW + CAW,
  localparam int FRAC  = CW - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic [NW-1:0]   tap_count,
  input  logic            sym_mode,
  input  logic            coef_we,
  input  logic [CAW-1:0]  coef_addr,
  input  logic [CW-1:0]   coef_wdata,
  output logic            out_valid,
  output logic [OW-1:0]   out_data,
  output logic            busy,
  output logic            overrun
);
  logic            wr_en, iss_valid, iss_last, iss_center, iss_sym;
  logic [PTRW-1:0] wr_addr, rd_a, rd_b;
  logic [CAW-1:0]  c_addr;
  logic [CW-1:0]   coef_q;
  logic [DW-1:0]   hist_q  [2];
  logic [PTRW-1:0] hist_ra [2];

  fir_fold_ctrl #(.TAPS(TAPS), .CDEPTH(CDEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .tap_count(tap_count),
    .sym_mode(sym_mode), .done(out_valid), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_a(rd_a), .rd_b(rd_b), .c_addr(c_addr), .iss_valid(iss_valid),
    .iss_last(iss_last), .iss_center(iss_center), .iss_sym(iss_sym),
    .busy(busy), .overrun(overrun)
  );

  assign hist_ra[0] = rd_a;
  assign hist_ra[1] = rd_b;

  // Two identical history copies give two reads per cycle.
  for (genvar p = 0; p < 2; p++) begin : g_hist
    fir_sdp_ram #(.W(DW), .DEPTH(TAPS)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
      .raddr(hist_ra[p]), .rdata(hist_q[p])
    );
  end

  fir_sdp_ram #(.W(CW), .DEPTH(CDEPTH)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr(c_addr), .rdata(coef_q)
  );

  fir_fold_mac #(.DW(DW), .CW(CW), .OW(OW), .ACCW(ACCW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .in_valid(iss_valid), .in_last(iss_last),
    .in_center(iss_center), .in_sym(iss_sym),
    .a($signed(hist_q[0])), .b($signed(hist_q[1])), .coef($signed(coef_q)),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R6: busy is released on the edge after the result strobe
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !busy);
  // R7: a result only appears during an accepted computation
  a_r7_out_in_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
endmodule

// File: tb/sim_fir_fold_core.sv
`timescale 1ns/1ps
module sim_fir_fold_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [9:0] tap_count = 10'd1;
  logic sym_mode = 1'b0;
  logic coef_we = 1'b0;
  logic [7:0] coef_addr = '0;
  logic [15:0] coef_wdata = '0;
  logic out_valid, busy, overrun;
  logic signed [15:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t0 = 0;
  longint hist [4096];
  int hcnt = 0;
  longint coefm [256];
  longint exp_y;
  int exp_lat;
  longint got_y;
  int got_lat;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  fir_fold_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tap_count(tap_count), .sym_mode(sym_mode), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .out_valid(out_valid),
    .out_data(out_data), .busy(busy), .overrun(overrun)
  );

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint xs(int j);
    return (j < hcnt) ? hist[hcnt-1-j] : 0;
  endfunction

  function automatic void model(int n, bit sym);
    int ne = (n == 0) ? 1 : n;
    int m;
    longint acc = 0;
    longint r;
    if (!sym && ne > 256) ne = 256;
    if (ne > 512) ne = 512;
    m = sym ? (ne + 1) / 2 : ne;
    for (int k = 0; k < m; k++) begin
      if (sym && (k != ne - 1 - k)) acc += (xs(k) + xs(ne-1-k)) * coefm[k];
      else acc += xs(k) * coefm[k];
    end
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    exp_y = r;
    exp_lat = m + 2;
  endfunction

  task automatic load_coef(int a, longint v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 8'(a); coef_wdata = 16'(v);
    @(posedge clk); #1;
    coef_we = 1'b0;
    coefm[a] = v;
  endtask

  task automatic start_run(longint s, int n, bit sym);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_data = 16'(s); tap_count = 10'(n); sym_mode = sym;
    @(posedge clk); #1;
    in_valid = 1'b0;
    t0 = cyc;
    hist[hcnt] = s; hcnt++;
    model(n, sym);
  endtask

  task automatic wait_out();
    int guard = 0;
    @(negedge clk);
    while (!out_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got_lat = cyc - t0;
    got_y = longint'(out_data);
  endtask

  task automatic run_one(string req, longint s, int n, bit sym, bit chk_lat);
    start_run(s, n, sym);
    wait_out();
    chk(req, "result", got_y, exp_y);
    if (chk_lat) chk("R4", "latency", got_lat, exp_lat);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "out_data", out_data, 0);
  endtask

  task automatic t_coefs();
    for (int k = 0; k < 256; k++) load_coef(k, (((k * 37) % 201) - 100) * 200);
  endtask

  task automatic t_asym();
    // R2 basic asymmetric, several sample patterns; R6 busy and pulse shape
    start_run(1000, 8, 0);
    @(negedge clk);
    chk("R6", "busy after accept", busy, 1);
    wait_out();
    chk("R2", "asym first", got_y, exp_y);
    chk("R4", "asym latency", got_lat, exp_lat);
    @(negedge clk);
    chk("R6", "pulse ended", out_valid, 0);
    chk("R6", "busy released", busy, 0);
    run_one("R2", -2500, 8, 0, 0);
    run_one("R2", 7777, 8, 0, 0);
    run_one("R2", -32768, 5, 0, 1);
  endtask

  task automatic t_asym_edges();
    run_one("R2", 321, 0, 0, 1);      // zero taps -> one tap
    for (int i = 0; i < 20; i++)
      run_one("R10", ((i * 7919) % 4001 - 2000) * 8, 3, 0, 0);
    run_one("R2", 1234, 300, 0, 1);   // clamp to 256, long history
  endtask

  task automatic t_sym();
    run_one("R3", 4000, 12, 1, 1);
    run_one("R3", -3000, 7, 1, 1);    // odd: centre once
    run_one("R3", 2222, 1, 1, 1);
    run_one("R3", 555, 512, 1, 1);
    run_one("R3", -555, 600, 1, 1);   // clamp to 512
  endtask

  task automatic t_latch();
    start_run(9000, 12, 1);
    tap_count = 10'd3; sym_mode = 1'b0;
    wait_out();
    chk("R8", "settings latched", got_y, exp_y);
    chk("R8", "latched latency", got_lat, exp_lat);
  endtask

  task automatic t_overrun();
    start_run(100, 40, 1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'd999;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7", "overrun flag", overrun, 1);
    @(negedge clk);
    chk("R7", "overrun one cycle", overrun, 0);
    wait_out();
    chk("R7", "result unaffected", got_y, exp_y);
    run_one("R7", 5, 40, 1, 0);       // dropped sample absent from history
  endtask

  task automatic t_round();
    load_coef(0, 16384);              // R9: rewrite entry 0 to one half
    run_one("R5", 1, 1, 0, 0);
    run_one("R5", -1, 1, 0, 0);
    run_one("R5", 3, 1, 0, 0);
    chk("R5", "half rounds up", got_y, 2);
  endtask

  task automatic t_sat();
    for (int k = 0; k < 8; k++) load_coef(k, 32767);
    for (int i = 0; i < 8; i++) run_one("R5", 32767, 8, 0, 0);
    chk("R5", "positive rail", got_y, 32767);
    for (int i = 0; i < 8; i++) run_one("R5", -32768, 8, 0, 0);
    chk("R5", "negative rail", got_y, -32768);
    run_one("R9", 10, 1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) coefm[i] = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_coefs();
    t_asym();
    t_asym_edges();
    t_sym();
    t_latch();
    t_overrun();
    t_round();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule